// File: doc/BRIEF.md
# Active-Low Serial Bit Engine

This block is the bit-level engine on the master side of a two-wire link made of a master-generated clock and one bidirectional data line. The data line uses inverted polarity: a logical 1 travels as a low wire level. The engine serialises or deserialises one message per request. Higher-level framing, CRC and retry logic sit above it and are not part of it.

A send request makes the engine drive one start bit and then the payload, most significant bit first, for 1 to `MSG_W` bits. A receive request leaves the data driver off and clocks in the requested number of bits. Each bit is inverted and shifted into the low end of a result word, and a running bit total grows with every bit received. Each link clock period is a low phase followed by a high phase of equal, programmable length. Outgoing data changes only at the falling edge and stays put through the high phase. Incoming data passes a two-flop synchronizer and is taken at the end of the high phase.

Top module: `nserial_engine`

## Requirements
- R1: After reset, `lnk_clk` is 1, `lnk_doe` is 0, `busy` and `done` are 0, and `rx_word` and `rx_count` are 0. When idle, the clock stays high and the driver stays off.
- R2: A send places one start bit (wire level 0, with `lnk_doe`=1) on the line for the first full clock period after the request is accepted.
- R3: After the start bit, a send carries the low `req_bits` bits of `req_payload`, most significant bit first, one bit per clock period. The wire level is the inverse of the logical bit. `lnk_doe` is 1 for the whole transfer.
- R4: A request with `req_bits`=0 is rejected. No clock pulse appears, `busy` stays 0 and `done` does not pulse.
- R5: Every low phase and every high phase of `lnk_clk` lasts E system cycles, where E = `ph_len`. Values of `ph_len` below 3 are treated as 3. The value is latched when the request is accepted.
- R6: While `lnk_clk` stays high during a transfer, `lnk_dout` does not change. The data level changes only in the cycle where the clock falls, or when the transfer ends.
- R7: During a receive, `lnk_doe` is 0. Each bit is stored inverted (wire low gives 1) and shifted into bit 0 of `rx_word`, with earlier bits moving up. `rx_count` rises by exactly one per received bit and carries over between receives.
- R8: A received bit is the wire level present two system cycles before the end of the high phase. What the line carries during the low phase has no effect.
- R9: `busy` rises in the cycle after acceptance and falls when the last period's high phase ends. A send with n bits takes n+1 clock periods and a receive takes n. `done` pulses for exactly one cycle, in the same cycle that `busy` falls.
- R10: A request made while `busy` is 1 is ignored. The running transfer's bits, length and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_rx | input | 1 | 1 = receive, 0 = send |
| req_bits | input | CNT_W (7) | Bit count; 0 is rejected, values above MSG_W are clamped to MSG_W |
| req_payload | input | MSG_W (64) | Send data, right-aligned |
| ph_len | input | PH_W (8) | Length of each clock phase in system cycles (minimum 3) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_word | output | MSG_W (64) | Received bits, newest in bit 0 |
| rx_count | output | ACC_W (16) | Running count of received bits |
| lnk_clk | output | 1 | Link clock, idles high |
| lnk_dout | output | 1 | Link data drive level (active-low data) |
| lnk_doe | output | 1 | Link data driver enable |
| lnk_din | input | 1 | Link data wire level, asynchronous |

## Verification
A wrong phase counter shows up within one clock period as a low or high phase whose length differs from the latched phase length. A wrong bit counter or start-bit flag changes the number of link clock periods, and that difference appears when `done` pulses. A fault in the send shift register shows up at the first rising edge that carries a wrong bit. A receive path that samples at the wrong moment takes in the deliberately wrong low-phase level, so the result word is wrong on the very next `done`. The checker catches driver-enable or hold violations in the cycle where they happen.

// File: rtl/nser_pkg.sv
package nser_pkg;

    // Shortest phase allowed: the synchronizer latency plus one cycle of margin.
    localparam int MIN_PHASE = 3;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic is_rx;       // current transfer receives
        logic start_pend;  // start-bit period still running
    } ctl_t;

endpackage

// File: rtl/nser_sync.sv
module nser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/nser_phase_gen.sv
module nser_phase_gen
    import nser_pkg::*;
#(
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            launch,
    input  logic [PH_W-1:0] len,
    input  logic            cont,
    output logic            active,
    output logic            lnk_clk,
    output logic            high_end
);
    phase_e          phase;
    logic [PH_W-1:0] cnt;
    logic [PH_W-1:0] len_q;
    logic            at_end;

    assign at_end   = (cnt == len_q - 1'b1);
    assign high_end = active && (phase == PH_HIGH) && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            phase   <= PH_HIGH;
            cnt     <= '0;
            len_q   <= PH_W'(MIN_PHASE);
            lnk_clk <= 1'b1;
        end else if (launch) begin
            active  <= 1'b1;
            phase   <= PH_LOW;
            cnt     <= '0;
            len_q   <= len;
            lnk_clk <= 1'b0;
        end else if (active) begin
            if (at_end) begin
                cnt <= '0;
                if (phase == PH_LOW) begin
                    phase   <= PH_HIGH;
                    lnk_clk <= 1'b1;
                end else if (cont) begin
                    phase   <= PH_LOW;
                    lnk_clk <= 1'b0;
                end else begin
                    active  <= 1'b0;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nser_shifter.sv
module nser_shifter #(
    parameter int MSG_W = 64,
    parameter int CNT_W = 7,
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             load_rx,
    input  logic [CNT_W-1:0] load_bits,
    input  logic [MSG_W-1:0] load_payload,
    input  logic             step,
    input  logic             last,
    input  logic             is_rx,
    input  logic             start_pend,
    input  logic             din_s,
    output logic             lnk_dout,
    output logic             lnk_doe,
    output logic [MSG_W-1:0] rx_word,
    output logic [ACC_W-1:0] rx_count
);
    logic [MSG_W-1:0] shreg;
    logic [CNT_W-1:0] pad;
    logic [MSG_W-1:0] aligned;
    logic             next_wire;

    assign pad     = CNT_W'(MSG_W) - load_bits;
    assign aligned = load_payload << pad;

    // Wire level for the coming period; the shift register moves on the same edge.
    always_comb begin
        if (start_pend) next_wire = ~shreg[MSG_W-1];
        else            next_wire = ~shreg[MSG_W-2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            lnk_dout <= 1'b1;
            lnk_doe  <= 1'b0;
            rx_word  <= '0;
            rx_count <= '0;
        end else if (load) begin
            if (load_rx) begin
                lnk_doe <= 1'b0;
            end else begin
                shreg    <= aligned;
                lnk_doe  <= 1'b1;
                lnk_dout <= 1'b0;          // start bit
            end
        end else if (step) begin
            if (is_rx) begin
                rx_word  <= {rx_word[MSG_W-2:0], ~din_s};
                rx_count <= rx_count + 1'b1;
            end else if (!start_pend) begin
                shreg <= shreg << 1;
            end
            if (last) begin
                lnk_doe <= 1'b0;
                if (!lnk_dout) lnk_dout <= 1'b1;
            end else if (!is_rx && (next_wire != lnk_dout)) begin
                lnk_dout <= next_wire;
            end
        end
    end
endmodule

// File: rtl/nserial_engine.sv
module nserial_engine
    import nser_pkg::*;
#(
    parameter int  MSG_W       = 64,
    parameter int  PH_W        = 8,
    parameter int  ACC_W       = 16,
    parameter int  SYNC_STAGES = 2,
    localparam int CNT_W       = $clog2(MSG_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_rx,
    input  logic [CNT_W-1:0] req_bits,
    input  logic [MSG_W-1:0] req_payload,
    input  logic [PH_W-1:0]  ph_len,
    output logic             busy,
    output logic             done,
    output logic [MSG_W-1:0] rx_word,
    output logic [ACC_W-1:0] rx_count,
    output logic             lnk_clk,
    output logic             lnk_dout,
    output logic             lnk_doe,
    input  logic             lnk_din
);
    ctl_t             ctl;
    logic [CNT_W-1:0] bits_left;
    logic [CNT_W-1:0] bits_eff;
    logic [PH_W-1:0]  len_eff;
    logic             accept;
    logic             cont;
    logic             high_end;
    logic             finish;
    logic             din_s;
    logic             rx_mode;

    assign bits_eff = (req_bits > CNT_W'(MSG_W)) ? CNT_W'(MSG_W) : req_bits;
    assign len_eff  = (ph_len < PH_W'(MIN_PHASE)) ? PH_W'(MIN_PHASE) : ph_len;
    assign accept   = req_valid && !busy && (bits_eff != '0);
    assign cont     = (!ctl.is_rx && ctl.start_pend) || (bits_left > CNT_W'(1));
    assign finish   = high_end && !cont;
    assign rx_mode  = ctl.is_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '0;
            bits_left <= '0;
            done      <= 1'b0;
        end else begin
            done <= finish;
            if (accept) begin
                ctl.is_rx      <= req_rx;
                ctl.start_pend <= !req_rx;
                bits_left      <= bits_eff;
            end else if (high_end) begin
                ctl.start_pend <= 1'b0;
                if (ctl.is_rx || !ctl.start_pend) bits_left <= bits_left - 1'b1;
            end
        end
    end

    nser_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (lnk_din),
        .q   (din_s)
    );

    nser_phase_gen #(.PH_W(PH_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .launch   (accept),
        .len      (len_eff),
        .cont     (cont),
        .active   (busy),
        .lnk_clk  (lnk_clk),
        .high_end (high_end)
    );

    nser_shifter #(.MSG_W(MSG_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_shift (
        .clk          (clk),
        .rst          (rst),
        .load         (accept),
        .load_rx      (req_rx),
        .load_bits    (bits_eff),
        .load_payload (req_payload),
        .step         (high_end),
        .last         (finish),
        .is_rx        (ctl.is_rx),
        .start_pend   (ctl.start_pend),
        .din_s        (din_s),
        .lnk_dout     (lnk_dout),
        .lnk_doe      (lnk_doe),
        .rx_word      (rx_word),
        .rx_count     (rx_count)
    );
endmodule

// File: rtl/nser_checker.sv
module nser_checker #(
    parameter int CNT_W = 7,
    parameter int ACC_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [CNT_W-1:0] req_bits,
    input logic             busy,
    input logic             done,
    input logic             lnk_clk,
    input logic             lnk_dout,
    input logic             lnk_doe,
    input logic [ACC_W-1:0] rx_count,
    input logic             rx_mode
);
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lnk_clk && !lnk_doe)); // R1

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && !rx_mode) |-> (!lnk_dout && lnk_doe)); // R2

    AST_TX_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        (busy && !rx_mode) |-> lnk_doe); // R3

    AST_ZERO_REJECT: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && (req_bits == '0)) |=> !busy); // R4

    AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && lnk_clk && $past(lnk_clk) && $past(busy)) |-> $stable(lnk_dout)); // R6

    AST_RX_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (busy && rx_mode) |-> !lnk_doe); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (rx_count != $past(rx_count)) |-> (rx_count == $past(rx_count) + 1'b1)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R9
endmodule

bind nserial_engine nser_checker #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_bits  (req_bits),
    .busy      (busy),
    .done      (done),
    .lnk_clk   (lnk_clk),
    .lnk_dout  (lnk_dout),
    .lnk_doe   (lnk_doe),
    .rx_count  (rx_count),
    .rx_mode   (rx_mode)
);

// File: tb/nserial_engine_test.sv
`timescale 1ns/1ps
module nserial_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_rx = 1'b0;
    logic [6:0]  req_bits = '0;
    logic [63:0] req_payload = '0;
    logic [7:0]  ph_len = 8'd3;
    logic        busy, done, lnk_clk, lnk_dout, lnk_doe;
    logic        lnk_din = 1'b1;
    logic [63:0] rx_word;
    logic [15:0] rx_count;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    nserial_engine uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_rx(req_rx),
        .req_bits(req_bits), .req_payload(req_payload), .ph_len(ph_len),
        .busy(busy), .done(done), .rx_word(rx_word), .rx_count(rx_count),
        .lnk_clk(lnk_clk), .lnk_dout(lnk_dout), .lnk_doe(lnk_doe),
        .lnk_din(lnk_din)
    );

    // monitor / slave model state
    logic        mode_rx = 1'b0;
    int          exp_len = 3;
    logic [63:0] sl_data = '0;
    int          sl_n = 0;
    int          rises = 0, lo_cnt = 0, hi_cnt = 0;
    int          ph_bad = 0, hold_bad = 0, doe_bad = 0, done_cnt = 0;
    logic        start_ok = 1'b0;
    logic [63:0] cap = '0;
    logic        p_clk = 1'b1, p_busy = 1'b0, p_dout = 1'b1;
    logic [63:0] acc_word = '0;
    logic [15:0] acc_cnt = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] lowmask(input int n);
        return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
    endfunction

    function automatic int eff(input int l);
        return (l < 3) ? 3 : l;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (busy && !lnk_clk && p_clk) begin
                if (p_busy && hi_cnt != exp_len) ph_bad++;
                lo_cnt = 1;
                if (mode_rx && rises < sl_n) lnk_din = sl_data[sl_n-1-rises]; // wrong level in low phase
            end else if (busy && !lnk_clk) begin
                lo_cnt++;
            end
            if (busy && lnk_clk && !p_clk) begin
                if (lo_cnt != exp_len) ph_bad++;
                hi_cnt = 1;
                if (!mode_rx) begin
                    if (rises == 0) start_ok = !lnk_dout && lnk_doe;
                    else            cap = {cap[62:0], ~lnk_dout};
                end else if (rises < sl_n) begin
                    lnk_din = ~sl_data[sl_n-1-rises];
                end
                rises++;
            end else if (busy && lnk_clk) begin
                hi_cnt++;
                if (lnk_dout != p_dout) hold_bad++;
            end
            if (p_busy && !busy && hi_cnt != exp_len) ph_bad++;
            if (busy && mode_rx && lnk_doe) doe_bad++;
            if (busy && !mode_rx && !lnk_doe) doe_bad++;
            if (done) done_cnt++;
            p_clk = lnk_clk; p_busy = busy; p_dout = lnk_dout;
        end
    end

    task automatic run(input bit rx, input int n, input logic [63:0] data,
                       input int l, input bit poke);
        int guard;
        @(negedge clk);
        mode_rx = rx; exp_len = eff(l); sl_data = data; sl_n = n;
        rises = 0; ph_bad = 0; hold_bad = 0; doe_bad = 0; done_cnt = 0;
        start_ok = 1'b0; cap = '0;
        req_valid = 1'b1; req_rx = rx; req_bits = 7'(n);
        req_payload = data; ph_len = 8'(l);
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            req_valid = 1'b1; req_rx = ~rx; req_bits = 7'd1;
            req_payload = ~data; ph_len = 8'd9;
            @(negedge clk);
            req_valid = 1'b0;
        end
        guard = 0;
        while (!done && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        @(posedge clk);
        #1;
        chk(done_cnt == 1, "R9", "done pulse count", 64'(done_cnt), 64'd1);
        chk(busy == 1'b0, "R9", "busy after done", 64'(busy), 64'd0);
        chk(ph_bad == 0, "R5", "phase length errors", 64'(ph_bad), 64'd0);
        if (!rx) begin
            chk(rises == n + 1, "R9 R10", "send periods", 64'(rises), 64'(n + 1));
            chk(start_ok, "R2", "start bit", 64'(start_ok), 64'd1);
            chk((cap & lowmask(n)) == (data & lowmask(n)), "R3 R10", "sent bits",
                cap & lowmask(n), data & lowmask(n));
            chk(doe_bad == 0, "R3", "driver off during send", 64'(doe_bad), 64'd0);
            chk(hold_bad == 0, "R6", "data moved in high phase", 64'(hold_bad), 64'd0);
        end else begin
            acc_word = (n >= 64) ? data : ((acc_word << n) | (data & lowmask(n)));
            acc_cnt  = acc_cnt + 16'(n);
            chk(rises == n, "R9 R10", "receive periods", 64'(rises), 64'(n));
            chk(rx_word == acc_word, "R7 R8", "received word", rx_word, acc_word);
            chk(rx_count == acc_cnt, "R7", "bit total", 64'(rx_count), 64'(acc_cnt));
            chk(doe_bad == 0, "R7", "driver on during receive", 64'(doe_bad), 64'd0);
        end
        lnk_din = 1'b1;
    endtask

    task automatic zero_req();
        int seen;
        @(negedge clk);
        rises = 0; done_cnt = 0; seen = 0;
        req_valid = 1'b1; req_rx = 1'b0; req_bits = 7'd0; req_payload = '1; ph_len = 8'd3;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (busy || !lnk_clk || lnk_doe) seen++;
        end
        chk(seen == 0, "R4", "activity on zero count", 64'(seen), 64'd0);
        chk(done_cnt == 0, "R4", "done on zero count", 64'(done_cnt), 64'd0);
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(lnk_clk == 1'b1, "R1", "idle clock", 64'(lnk_clk), 64'd1);
        chk(lnk_doe == 1'b0, "R1", "idle driver", 64'(lnk_doe), 64'd0);
        chk(busy == 1'b0 && done == 1'b0, "R1", "idle busy/done", 64'({busy, done}), 64'd0);
        chk(rx_word == '0 && rx_count == '0, "R1", "reset results", rx_word, 64'd0);

        // directed corner cases
        run(1'b0, 1,  64'h1, 0, 1'b0);
        run(1'b0, 64, 64'hAAAA_5555_F0F0_0F0F, 3, 1'b0);
        run(1'b0, 16, 64'hFFFF, 4, 1'b0);
        run(1'b0, 12, 64'h0, 5, 1'b1);
        zero_req();
        run(1'b1, 1,  64'h1, 1, 1'b0);
        run(1'b1, 7,  64'h55, 3, 1'b1);
        run(1'b1, 64, 64'h0123_4567_89AB_CDEF, 3, 1'b0);
        run(1'b1, 9,  64'h0, 6, 1'b0);

        // constrained random mix
        for (int i = 0; i < 24; i++) begin
            run(1'($urandom % 2), 1 + int'($urandom % 64),
                {$urandom, $urandom}, int'($urandom % 7), 1'($urandom % 4 == 0));
        end
        zero_req();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule